// File: doc/BRIEF.md
# Strobe-Slot Power Rail Sequencer

This block switches a bank of supply-rail enables on and off in numbered time slots called strobes. Each rail carries a small register that names the slot it belongs to. Slot 0 means the rail is never switched. A power-up walks slots 1 through 15 in rising order and turns on the rails assigned to each slot. A power-down walks the slots from 15 downward and turns the same rails off. Each slot lasts for a number of clock cycles set by its own delay field.

Rails 0 and 1 are the always-on pair. Only they may use slots 1 and 2, which are the first slots of every power-up, so this pair comes up as soon as the sequencer leaves OFF. Both slots run on every power-up, even when the pair is already on. A seal input, captured when a power-down starts, decides the end of the power-down. With the seal clear, the walk continues down to slot 1 and ends in OFF. With the seal set, the walk stops after slot 3, the pair keeps its state, and the sequencer ends in SUSPEND or RECOVERY depending on the cause.

The block is driven by a power-enable level, a fault level (thermal shutdown or undervoltage), the slot and delay registers and the seal bit. It reports a settled state code and a one-cycle completion pulse.

Top module: `rail_strobe_seq`

## Requirements
- R1: After reset every rail enable is low, state_o is 0 (OFF) and seq_done_o is low.
- R2: Power-up starts on the edge where the sequencer first sees pwr_en_i high with fault_i low, in OFF, SUSPEND or RECOVERY. Slot 1 starts on that edge. Slot s lasts d(s)+1 cycles, where d(s) is bits [(s-1)*8 +: 8] of slot_dly_i. The slots run 1 to 15 in order. A rail assigned to slot s goes high one clock after slot s starts.
- R3: The slot field of rail r is bits [r*4 +: 4] of rail_slot_i. Rails 0 and 1 accept only the values 1 and 2. Every other rail accepts only the values 3 to 15. A rail holding a value it does not accept is never enabled.
- R4: A rail whose slot field is 0 is never enabled.
- R5: Power-down starts on the edge where the sequencer, in ACTIVE, sees pwr_en_i low or fault_i high. Slot 15 starts on that edge, and the slots then run downward with the same durations. A rail goes low one clock after its own slot starts.
- R6: When seal_i is 1 at the start of power-down, the walk ends after slot 3. Slots 1 and 2 take no time, and rails 0 and 1 keep their enable.
- R7: state_o encodes 0 as OFF, 1 as ACTIVE, 2 as SUSPEND and 3 as RECOVERY. It changes only on the edge that ends a sequence. A power-up ends in ACTIVE. A power-down with the seal clear ends in OFF. With the seal set, a power-down caused by fault ends in RECOVERY, and one caused by pwr_en_i low ends in SUSPEND.
- R8: A power-up from SUSPEND or RECOVERY still spends the full durations of slots 1 and 2. Rails 0 and 1 stay high throughout.
- R9: A power-up request that arrives during power-down waits until the power-down ends. The new power-up starts on the following edge.
- R10: seq_done_o is high for exactly one cycle. That cycle follows the edge that ends the last slot of a power-up or a power-down.
- R11: During power-up, the power-enable and fault inputs are not evaluated. The power-up always completes before a power-down can begin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pwr_en_i | input | 1 | Power-enable request level |
| fault_i | input | 1 | Thermal-shutdown or undervoltage fault level |
| seal_i | input | 1 | Keep the always-on pair at power-down when high |
| rail_slot_i | input | NRAIL*4 | Slot assignment for each rail, 4 bits per rail |
| slot_dly_i | input | (NSLOT-1)*DLY_W | Extra cycles for each of slots 1..15 |
| rail_en_o | output | NRAIL | Rail enable lines |
| state_o | output | 2 | Settled state code |
| seq_done_o | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
The entry edge is the edge on which the sequencer acts on a request. It falls one edge after the input change, which the bench drives on a falling edge. Every result is due a fixed number of cycles after this edge, and the bench derives each one from the slot delays alone. A rail enable changes at the entry edge plus the summed lengths of the earlier slots in the walk, plus one cycle for its register. The completion pulse and the new state code appear at the entry edge plus the summed lengths of every slot walked. The bench keeps a free-running cycle count and records, on falling edges, the first cycle each enable rose or fell and when the pulse was seen. It compares those records with the computed cycles. It also checks that every rail that should be left alone never moved.

// File: rtl/rss_pkg.sv
package rss_pkg;
  typedef enum logic [2:0] {
    PH_OFF, PH_UP, PH_ACT, PH_DOWN, PH_SUSP, PH_RECV
  } phase_e;

  typedef enum logic [1:0] {
    ST_OFF      = 2'd0,
    ST_ACTIVE   = 2'd1,
    ST_SUSPEND  = 2'd2,
    ST_RECOVERY = 2'd3
  } state_e;
endpackage

// File: rtl/rss_slot_map.sv
// Filters each rail's slot field: the always-on pair keeps only slots 1/2,
// every other rail keeps only slots 3 and up. Rejected values map to 0.
module rss_slot_map #(
  parameter int NRAIL    = 6,
  parameter int AO_RAILS = 2,
  parameter int SW       = 4
) (
  input  logic [NRAIL*SW-1:0] rail_slot_i,
  output logic [NRAIL*SW-1:0] eff_slot_o
);
  for (genvar r = 0; r < NRAIL; r++) begin : g_rail
    logic [SW-1:0] raw;
    assign raw = rail_slot_i[r*SW +: SW];
    if (r < AO_RAILS) begin : g_ao
      assign eff_slot_o[r*SW +: SW] =
        (raw == SW'(1) || raw == SW'(2)) ? raw : '0;
    end else begin : g_std
      assign eff_slot_o[r*SW +: SW] = (raw >= SW'(3)) ? raw : '0;
    end
  end
endmodule

// File: rtl/rss_seq_ctrl.sv
// Phase machine, slot pointer and per-slot dwell timer.
module rss_seq_ctrl
  import rss_pkg::*;
#(
  parameter int NSLOT = 16,
  parameter int DW    = 8,
  parameter int SW    = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pwr_en_i,
  input  logic                    fault_i,
  input  logic                    seal_i,
  input  logic [(NSLOT-1)*DW-1:0] slot_dly_i,
  output phase_e                  phase_o,
  output logic [SW-1:0]           cur_o,
  output logic                    done_o,
  output state_e                  state_o
);
  localparam int LAST = NSLOT - 1;

  logic [DW-1:0] dly_a [NSLOT];
  assign dly_a[0] = '0;
  for (genvar s = 1; s <= LAST; s++) begin : g_dly
    assign dly_a[s] = slot_dly_i[(s-1)*DW +: DW];
  end

  phase_e        ph_q, ph_d;
  state_e        st_q, st_d;
  logic [SW-1:0] cur_q, cur_d;
  logic [DW-1:0] tm_q, tm_d;
  logic          seal_q, seal_d, flt_q, flt_d, done_q, done_d;
  logic          up_req, dn_req, tm_zero;
  logic [SW-1:0] stop_slot;

  assign up_req    = pwr_en_i && !fault_i;
  assign dn_req    = !pwr_en_i || fault_i;
  assign tm_zero   = (tm_q == '0);
  assign stop_slot = seal_q ? SW'(3) : SW'(1);

  always_comb begin
    ph_d   = ph_q;
    st_d   = st_q;
    cur_d  = cur_q;
    tm_d   = tm_q;
    seal_d = seal_q;
    flt_d  = flt_q;
    done_d = 1'b0;
    case (ph_q)
      PH_OFF, PH_SUSP, PH_RECV: begin
        if (up_req) begin
          ph_d  = PH_UP;
          cur_d = SW'(1);
          tm_d  = dly_a[1];
        end
      end
      PH_UP: begin
        if (!tm_zero) begin
          tm_d = tm_q - DW'(1);
        end else if (cur_q == SW'(LAST)) begin
          ph_d   = PH_ACT;
          st_d   = ST_ACTIVE;
          done_d = 1'b1;
        end else begin
          cur_d = cur_q + SW'(1);
          tm_d  = dly_a[cur_q + SW'(1)];
        end
      end
      PH_ACT: begin
        if (dn_req) begin
          ph_d   = PH_DOWN;
          cur_d  = SW'(LAST);
          tm_d   = dly_a[LAST];
          seal_d = seal_i;
          flt_d  = fault_i;
        end
      end
      PH_DOWN: begin
        if (!tm_zero) begin
          tm_d = tm_q - DW'(1);
        end else if (cur_q == stop_slot) begin
          done_d = 1'b1;
          if (!seal_q) begin
            ph_d = PH_OFF;
            st_d = ST_OFF;
          end else if (flt_q) begin
            ph_d = PH_RECV;
            st_d = ST_RECOVERY;
          end else begin
            ph_d = PH_SUSP;
            st_d = ST_SUSPEND;
          end
        end else begin
          cur_d = cur_q - SW'(1);
          tm_d  = dly_a[cur_q - SW'(1)];
        end
      end
      default: ph_d = PH_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_OFF;
      st_q   <= ST_OFF;
      cur_q  <= '0;
      tm_q   <= '0;
      seal_q <= 1'b0;
      flt_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      st_q   <= st_d;
      cur_q  <= cur_d;
      tm_q   <= tm_d;
      seal_q <= seal_d;
      flt_q  <= flt_d;
      done_q <= done_d;
    end
  end

  assign phase_o = ph_q;
  assign cur_o   = cur_q;
  assign done_o  = done_q;
  assign state_o = st_q;

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  p_seal_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_DOWN && seal_q) |-> (cur_q >= SW'(3)));
  p_active_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_ACT) |-> (st_q == ST_ACTIVE));
  p_busy_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_UP || ph_q == PH_DOWN) |-> (cur_q != '0));
  p_hold_request_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_DOWN) |=> (ph_q != PH_UP));
  p_up_uninterrupted_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_UP) |=> (ph_q == PH_UP || ph_q == PH_ACT));
endmodule

// File: rtl/rss_rail_bank.sv
// Rail enable registers: set on a matching slot while rising, cleared while falling.
module rss_rail_bank
  import rss_pkg::*;
#(
  parameter int NRAIL = 6,
  parameter int SW    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  phase_e              phase_i,
  input  logic [SW-1:0]       cur_i,
  input  logic [NRAIL*SW-1:0] eff_slot_i,
  output logic [NRAIL-1:0]    en_o
);
  logic [NRAIL-1:0] en_q, en_d, hit;
  logic             going_up, going_dn, upd_en;

  assign going_up = (phase_i == PH_UP);
  assign going_dn = (phase_i == PH_DOWN);
  assign upd_en   = going_up || going_dn;

  for (genvar r = 0; r < NRAIL; r++) begin : g_hit
    assign hit[r] = (eff_slot_i[r*SW +: SW] == cur_i);
  end

  always_comb begin
    en_d = en_q;
    if (going_up) en_d = en_q | hit;
    if (going_dn) en_d = en_q & ~hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (upd_en) begin
      en_q <= en_d;
    end
  end

  assign en_o = en_q;

  p_off_all_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i == PH_OFF) |-> (en_q == '0));
  p_up_no_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    going_up |=> ((en_q & $past(en_q)) == $past(en_q)));
  p_dn_no_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    going_dn |=> ((en_q & ~$past(en_q)) == '0));
endmodule

// File: rtl/rail_strobe_seq.sv
module rail_strobe_seq
  import rss_pkg::*;
#(
  parameter  int NRAIL = 6,
  parameter  int NSLOT = 16,
  parameter  int DLY_W = 8,
  localparam int SW    = $clog2(NSLOT)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       pwr_en_i,
  input  logic                       fault_i,
  input  logic                       seal_i,
  input  logic [NRAIL*SW-1:0]        rail_slot_i,
  input  logic [(NSLOT-1)*DLY_W-1:0] slot_dly_i,
  output logic [NRAIL-1:0]           rail_en_o,
  output logic [1:0]                 state_o,
  output logic                       seq_done_o
);
  localparam int AO_RAILS = 2;

  logic [NRAIL*SW-1:0] eff_slot;
  phase_e              phase;
  state_e              st;
  logic [SW-1:0]       cur;

  rss_slot_map #(.NRAIL(NRAIL), .AO_RAILS(AO_RAILS), .SW(SW)) u_map (
    .rail_slot_i (rail_slot_i),
    .eff_slot_o  (eff_slot)
  );

  rss_seq_ctrl #(.NSLOT(NSLOT), .DW(DLY_W), .SW(SW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_en_i   (pwr_en_i),
    .fault_i    (fault_i),
    .seal_i     (seal_i),
    .slot_dly_i (slot_dly_i),
    .phase_o    (phase),
    .cur_o      (cur),
    .done_o     (seq_done_o),
    .state_o    (st)
  );

  rss_rail_bank #(.NRAIL(NRAIL), .SW(SW)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase_i    (phase),
    .cur_i      (cur),
    .eff_slot_i (eff_slot),
    .en_o       (rail_en_o)
  );

  assign state_o = st;

  p_state_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_done_o |-> $stable(state_o));
endmodule

// File: tb/rail_strobe_seq_tb_top.sv
module rail_strobe_seq_tb_top;
  localparam int NR = 6, NS = 16, DW = 8, SW = 4, LAST = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_en = 1'b0, fault = 1'b0, seal = 1'b0;
  logic [NR*SW-1:0] rslot = '0;
  logic [(NS-1)*DW-1:0] sdly = '0;
  logic [NR-1:0] en;
  logic [1:0] st;
  logic done;

  rail_strobe_seq dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_en_i(pwr_en), .fault_i(fault),
    .seal_i(seal), .rail_slot_i(rslot), .slot_dly_i(sdly),
    .rail_en_o(en), .state_o(st), .seq_done_o(done)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, bad = 0;
  int rise_at [NR];
  int fall_at [NR];
  int done_n = 0, done_at = -1;
  logic [NR-1:0] prev = '0;
  int cur_pat = 0;

  always @(negedge clk) begin
    for (int r = 0; r < NR; r++) begin
      if (en[r] && !prev[r] && rise_at[r] < 0) rise_at[r] = cyc;
      if (!en[r] && prev[r] && fall_at[r] < 0) fall_at[r] = cyc;
    end
    prev = en;
    if (done) begin
      done_n++;
      done_at = cyc;
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog all requirements actual=%0d cycles expected=<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic int raw_slot(int c, int r);
    int a [NR] = '{1, 2, 3, 7, 15, 1};
    int b [NR] = '{2, 5, 2, 0, 9, 4};
    return (c == 0) ? a[r] : b[r];
  endfunction

  function automatic int eff(int c, int r);
    int v = raw_slot(c, r);
    if (r < 2) return (v == 1 || v == 2) ? v : 0;
    return (v >= 3) ? v : 0;
  endfunction

  function automatic int dly(int p, int s);
    case (p)
      0: return 0;
      1: return s % 4;
      default: return (s * 7) % 3;
    endcase
  endfunction

  function automatic int span(int p, int a, int b);
    int t = 0;
    for (int s = a; s <= b; s++) t += dly(p, s) + 1;
    return t;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic load(int c, int p);
    cur_pat = p;
    for (int r = 0; r < NR; r++) rslot[r*SW +: SW] = SW'(raw_slot(c, r));
    for (int s = 1; s <= LAST; s++) sdly[(s-1)*DW +: DW] = DW'(dly(p, s));
  endtask

  task automatic clear_mon();
    for (int r = 0; r < NR; r++) begin
      rise_at[r] = -1;
      fall_at[r] = -1;
    end
    done_n = 0;
    done_at = -1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    pwr_en = 1'b0;
    fault = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "state after reset", int'(st), 0);
    chk("R1", "enables after reset", int'(en), 0);
    chk("R1", "done after reset", int'(done), 0);
  endtask

  initial begin
    int c0, stop, e, up_len, dn_len, exp_st, dd;
    clear_mon();

    for (int c = 0; c < 2; c++)
      for (int p = 0; p < 3; p++)
        for (int sl = 0; sl < 2; sl++)
          for (int ca = 0; ca < 2; ca++) begin
            load(c, p);
            do_reset();
            seal = sl[0];
            up_len = span(p, 1, LAST);
            // power-up from OFF
            clear_mon();
            pwr_en = 1'b1;
            c0 = cyc + 1;
            repeat (up_len + 4) @(negedge clk);
            for (int r = 0; r < NR; r++) begin
              e = eff(c, r);
              if (e != 0) chk("R2", $sformatf("rail%0d rise", r), rise_at[r], c0 + span(p, 1, e - 1) + 1);
              else if (raw_slot(c, r) == 0) chk("R4", $sformatf("rail%0d rise", r), rise_at[r], -1);
              else chk("R3", $sformatf("rail%0d rise", r), rise_at[r], -1);
            end
            chk("R10", "up done count", done_n, 1);
            chk("R10", "up done cycle", done_at, c0 + up_len);
            chk("R7", "state after up", int'(st), 1);
            // power-down
            clear_mon();
            if (ca == 1) fault = 1'b1; else pwr_en = 1'b0;
            stop = (sl == 1) ? 3 : 1;
            dn_len = span(p, stop, LAST);
            c0 = cyc + 1;
            repeat (dn_len + 4) @(negedge clk);
            for (int r = 0; r < NR; r++) begin
              e = eff(c, r);
              if (e >= stop) chk("R5", $sformatf("rail%0d fall", r), fall_at[r], c0 + span(p, e + 1, LAST) + 1);
              else if (e != 0) begin
                chk("R6", $sformatf("rail%0d kept fall", r), fall_at[r], -1);
                chk("R6", $sformatf("rail%0d kept level", r), int'(en[r]), 1);
              end
            end
            chk("R10", "down done count", done_n, 1);
            chk("R10", "down done cycle", done_at, c0 + dn_len);
            exp_st = (sl == 0) ? 0 : ((ca == 1) ? 3 : 2);
            chk("R7", "state after down", int'(st), exp_st);
            // power-up again from SUSPEND or RECOVERY
            if (sl == 1) begin
              clear_mon();
              fault = 1'b0;
              pwr_en = 1'b1;
              c0 = cyc + 1;
              repeat (up_len + 4) @(negedge clk);
              for (int r = 0; r < NR; r++) begin
                e = eff(c, r);
                if (r < 2 && e != 0) begin
                  chk("R8", $sformatf("rail%0d fall", r), fall_at[r], -1);
                  chk("R8", $sformatf("rail%0d level", r), int'(en[r]), 1);
                end else if (e >= 3) begin
                  chk("R2", $sformatf("rail%0d re-rise", r), rise_at[r], c0 + span(p, 1, e - 1) + 1);
                end
              end
              chk("R8", "re-up done cycle", done_at, c0 + up_len);
              chk("R7", "state after re-up", int'(st), 1);
            end
          end

    // R9: request raised during power-down is held
    load(0, 1);
    do_reset();
    seal = 1'b0;
    pwr_en = 1'b1;
    repeat (span(1, 1, LAST) + 4) @(negedge clk);
    clear_mon();
    pwr_en = 1'b0;
    c0 = cyc + 1;
    repeat (4) @(negedge clk);
    pwr_en = 1'b1;
    dd = c0 + span(1, 1, LAST);
    repeat (2 * span(1, 1, LAST) + 8) @(negedge clk);
    chk("R9", "rail0 re-rise after held request", rise_at[0], dd + 2);
    chk("R9", "rail0 fall during down", fall_at[0], c0 + span(1, 2, LAST) + 1);
    chk("R9", "done pulses", done_n, 2);
    chk("R9", "state", int'(st), 1);

    // R11: power-enable dropped during power-up does not cut it short
    load(0, 2);
    do_reset();
    seal = 1'b0;
    clear_mon();
    pwr_en = 1'b1;
    c0 = cyc + 1;
    repeat (3) @(negedge clk);
    pwr_en = 1'b0;
    up_len = span(2, 1, LAST);
    repeat (2 * up_len + 8) @(negedge clk);
    chk("R11", "slot15 rail rise", rise_at[4], c0 + span(2, 1, LAST - 1) + 1);
    chk("R11", "done pulses", done_n, 2);
    chk("R11", "down done cycle", done_at, c0 + up_len + 1 + up_len);
    chk("R11", "final state", int'(st), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule